// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Controller

This block sits between the register bus of an SPI controller and its shift engine. It holds a transmit byte FIFO and a receive byte FIFO. The bus fills the transmit FIFO and empties the receive FIFO. The shift engine drains the transmit FIFO, fills the receive FIFO, and pulses a completion strobe when a transfer ends. The serial shifting itself happens outside this block.

Software programs two 8-bit trigger levels, two DMA-request enables and two self-clearing flush bits through a FIFO control word. It reads both fill counts from a status word. Four interrupt causes are recorded in a status register that is cleared by writing 1: receive ready, transmit refill request, receive overflow and transfer done. An enable register with the same bit layout masks them onto a single interrupt line. The same trigger comparisons, gated by the DMA enables, drive two DMA request lines.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After reset, the irq, rx_drq and tx_drq outputs are 0, and the control word (address 0), status word (address 1) and enable register (address 2) read as 0.
- R2: The control word at address 0 holds the RX trigger in bits 7:0, the RX DMA enable in bit 8, the TX trigger in bits 23:16 and the TX DMA enable in bit 24. All other bits read 0. A read returns the register contents one cycle after reg_addr is presented.
- R3: The status word at address 1 reads the RX fill count in bits 7:0 and the TX fill count in bits 23:16. Writes to address 1 have no effect. A push into a full FIFO leaves its count at DEPTH.
- R4: Each FIFO returns bytes in push order. Pop data appears on the data output in the cycle after the pop.
- R5: Receive ready (bit 0 of the status and enable registers at addresses 3 and 2) is set whenever the RX count is nonzero and greater than or equal to the RX trigger.
- R6: Transmit request (bit 4) is set whenever the TX count is less than or equal to the TX trigger.
- R7: A shift-engine push into a full RX FIFO sets overflow (bit 8), and the byte is dropped. The bytes already stored are kept unchanged.
- R8: Writing 1 to a status bit at address 3 clears it, and bits written 0 keep their value. A clear wins over a level cause in the write cycle. If the cause still holds, the bit is set again on the next cycle.
- R9: A done pulse sets bit 12. Overflow and done stay set until they are cleared, and an event that coincides with a clear of other bits is kept.
- R10: irq is 1 exactly when some status bit and its enable bit are both 1, registered one cycle after the status register.
- R11: rx_drq equals the RX DMA enable ANDed with the receive-ready condition, and tx_drq equals the TX DMA enable ANDed with the transmit-request condition, each registered one cycle after the counts and the control word.
- R12: Writing 1 to bit 15 of address 0 empties the RX FIFO, and writing 1 to bit 31 empties the TX FIFO. Both bits read back 0, and the other FIFO is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 FIFO status, 2 enable, 3 status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| bus_tx_push | input | 1 | Bus writes a byte into the TX FIFO |
| bus_tx_data | input | 8 | Byte to push into the TX FIFO |
| bus_rx_pop | input | 1 | Bus takes a byte from the RX FIFO |
| bus_rx_data | output | 8 | Byte popped from the RX FIFO |
| eng_tx_pop | input | 1 | Shift engine takes a byte from the TX FIFO |
| eng_tx_data | output | 8 | Byte popped from the TX FIFO |
| eng_rx_push | input | 1 | Shift engine pushes a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt request |
| rx_drq | output | 1 | RX DMA request |
| tx_drq | output | 1 | TX DMA request |

## Verification
A push or pop changes a fill count at the same clock edge, and a read returns it one edge later. A level status bit follows the count one edge after that, and irq follows the status bit one edge later. A DMA request follows the count or the control word one edge later. The bench therefore re-arms a level bit with a write-1 clear, lets one full cycle pass, and only then issues the read. It also samples irq right after the enable or clear write and again one cycle later, so each check lands on the edge at which the result is due. Sweeps step each FIFO through every count from empty to one past full under several trigger levels, and the expected flags, counts and data bytes are computed arithmetically.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [1:0] ADDR_FCTL = 2'd0;
  localparam logic [1:0] ADDR_FSTA = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;
  localparam logic [1:0] ADDR_ISTA = 2'd3;

  // cause index i lives at register bit 4*i
  localparam int CAUSE_RX_RDY = 0;
  localparam int CAUSE_TX_REQ = 1;
  localparam int CAUSE_RX_OVF = 2;
  localparam int CAUSE_DONE   = 3;
  localparam int NUM_CAUSE    = 4;

  function automatic logic [NUM_CAUSE-1:0] cause_pick(input logic [31:0] w);
    logic [NUM_CAUSE-1:0] v;
    for (int i = 0; i < NUM_CAUSE; i++) v[i] = w[4*i];
    return v;
  endfunction

  function automatic logic [31:0] cause_spread(input logic [NUM_CAUSE-1:0] v);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < NUM_CAUSE; i++) w[4*i] = v[i];
    return w;
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             pop,
  output logic [7:0]       dout,
  output logic [CNT_W-1:0] cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign push_ok = push && (cnt != CNT_W'(DEPTH));
  assign pop_ok  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  a_r3_cnt_limit: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && cnt == CNT_W'(DEPTH)) |=> cnt == $past(cnt));

  a_r12_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> cnt == '0);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int           N          = 4,
  parameter logic [N-1:0] LEVEL_MASK = 4'b0011
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_we,
  input  logic [N-1:0] clr_vec,
  input  logic         en_we,
  input  logic [N-1:0] en_vec,
  output logic [N-1:0] sts,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      // level causes lose against a clear, events always land
      sts <= (sts & ~clr_eff) | (set_vec & LEVEL_MASK & ~clr_eff) | (set_vec & ~LEVEL_MASK);
      if (en_we) en <= en_vec;
      irq <= |(sts & en);
    end
  end

  a_r8_level_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_vec[0] && LEVEL_MASK[0]) |=> !sts[0]);

  a_r9_event_sticks: assert property (@(posedge clk) disable iff (rst)
    set_vec[N-1] |=> sts[N-1]);

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq);
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        bus_tx_push,
  input  logic [7:0]  bus_tx_data,
  input  logic        bus_rx_pop,
  output logic [7:0]  bus_rx_data,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_done,
  output logic        irq,
  output logic        rx_drq,
  output logic        tx_drq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]           rx_trig, tx_trig;
  logic                 rx_drq_en, tx_drq_en;
  logic [CNT_W-1:0]     rx_cnt, tx_cnt;
  logic [7:0]           rx_cnt8, tx_cnt8;
  logic                 fctl_we, rx_flush, tx_flush;
  logic                 rx_rdy_c, tx_req_c, rx_ovf;
  logic [NUM_CAUSE-1:0] set_vec, sts, en;
  logic                 unused_wbits;

  assign unused_wbits = ^{reg_wdata[30:25], reg_wdata[14:13], reg_wdata[11:9]};

  assign fctl_we  = reg_we && (reg_addr == ADDR_FCTL);
  assign rx_flush = fctl_we && reg_wdata[15];
  assign tx_flush = fctl_we && reg_wdata[31];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_trig   <= '0;
      tx_trig   <= '0;
      rx_drq_en <= 1'b0;
      tx_drq_en <= 1'b0;
    end else if (fctl_we) begin
      rx_trig   <= reg_wdata[7:0];
      rx_drq_en <= reg_wdata[8];
      tx_trig   <= reg_wdata[23:16];
      tx_drq_en <= reg_wdata[24];
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(bus_tx_push), .din(bus_tx_data),
    .pop(eng_tx_pop), .dout(eng_tx_data), .cnt(tx_cnt)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(bus_rx_pop), .dout(bus_rx_data), .cnt(rx_cnt)
  );

  assign rx_cnt8  = 8'(rx_cnt);
  assign tx_cnt8  = 8'(tx_cnt);
  assign rx_rdy_c = (rx_cnt8 != 8'd0) && (rx_cnt8 >= rx_trig);
  assign tx_req_c = tx_cnt8 <= tx_trig;
  assign rx_ovf   = eng_rx_push && (rx_cnt == CNT_W'(DEPTH));

  always_comb begin
    set_vec               = '0;
    set_vec[CAUSE_RX_RDY] = rx_rdy_c;
    set_vec[CAUSE_TX_REQ] = tx_req_c;
    set_vec[CAUSE_RX_OVF] = rx_ovf;
    set_vec[CAUSE_DONE]   = eng_done;
  end

  irq_status_reg #(.N(NUM_CAUSE), .LEVEL_MASK(4'b0011)) u_status (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_we(reg_we && (reg_addr == ADDR_ISTA)), .clr_vec(cause_pick(reg_wdata)),
    .en_we(reg_we && (reg_addr == ADDR_IEN)), .en_vec(cause_pick(reg_wdata)),
    .sts(sts), .en(en), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_drq    <= 1'b0;
      tx_drq    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      rx_drq <= rx_drq_en && rx_rdy_c;
      tx_drq <= tx_drq_en && tx_req_c;
      case (reg_addr)
        ADDR_FCTL: reg_rdata <= {7'd0, tx_drq_en, tx_trig, 7'd0, rx_drq_en, rx_trig};
        ADDR_FSTA: reg_rdata <= {8'd0, tx_cnt8, 8'd0, rx_cnt8};
        ADDR_IEN:  reg_rdata <= cause_spread(en);
        default:   reg_rdata <= cause_spread(sts);
      endcase
    end
  end

  a_r11_rx_drq_gated: assert property (@(posedge clk) disable iff (rst)
    !rx_drq_en |=> !rx_drq);

  a_r11_tx_drq_gated: assert property (@(posedge clk) disable iff (rst)
    !tx_drq_en |=> !tx_drq);
endmodule

// File: tb/spi_fifo_irq_ctrl_tb.sv
module spi_fifo_irq_ctrl_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_tx_push = 1'b0;
  logic [7:0]  bus_tx_data = '0;
  logic        bus_rx_pop = 1'b0;
  logic [7:0]  bus_rx_data;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_tx_data;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_done = 1'b0;
  logic        irq, rx_drq, tx_drq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  spi_fifo_irq_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
    .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_done(eng_done), .irq(irq), .rx_drq(rx_drq), .tx_drq(tx_drq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    step();
    d = reg_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    eng_rx_push = 1'b1; eng_rx_data = b;
    step();
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] b);
    bus_tx_push = 1'b1; bus_tx_data = b;
    step();
    bus_tx_push = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [31:0] v;
    int rtrig [4] = '{1, 17, 48, 64};
    int ttrig [3] = '{0, 5, 63};

    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rx_drq", {31'd0, rx_drq}, 32'd0);
    check("R1 tx_drq", {31'd0, tx_drq}, 32'd0);
    rd(2'd0, v); check("R1 control", v, 32'd0);
    rd(2'd1, v); check("R1 fifo status", v, 32'd0);
    rd(2'd2, v); check("R1 enable", v, 32'd0);

    // R2 control layout, R12 flush bits read 0
    wr(2'd0, 32'h8135_8122);
    rd(2'd0, v); check("R2 control readback", v, 32'h0135_0122);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R3 status write ignored", v, 32'd0);

    // R3 R5 R7 R4 receive sweep
    foreach (rtrig[t]) begin
      wr(2'd0, 32'h0000_8000 | 32'(rtrig[t]));
      for (int k = 0; k <= DEPTH; k++) begin
        wr(2'd3, 32'hFFFF_FFFF);
        step();
        rd(2'd3, v);
        check("R5 rx ready level", v,
              ((k != 0 && k >= rtrig[t]) ? 32'h1 : 32'h0) | 32'h10);
        rd(2'd1, v);
        check("R3 rx count", v, 32'(k));
        rx_push(8'((k * 7 + rtrig[t]) & 255));
      end
      rd(2'd3, v);
      check("R7 overflow flag", v, 32'h111);
      rd(2'd1, v);
      check("R7 count held at depth", v, 32'(DEPTH));
      for (int i = 0; i < DEPTH; i++) begin
        bus_rx_pop = 1'b1;
        step();
        bus_rx_pop = 1'b0;
        check("R4 rx order", {24'd0, bus_rx_data}, 32'((i * 7 + rtrig[t]) & 255));
      end
      rd(2'd1, v);
      check("R7 dropped byte absent", v, 32'd0);
    end

    // R6 R3 R4 transmit sweep
    foreach (ttrig[t]) begin
      wr(2'd0, 32'h8000_0000 | (32'(ttrig[t]) << 16));
      for (int k = 0; k <= DEPTH; k++) begin
        wr(2'd3, 32'hFFFF_FFFF);
        step();
        rd(2'd3, v);
        check("R6 tx request level", v, (k <= ttrig[t]) ? 32'h10 : 32'h0);
        rd(2'd1, v);
        check("R3 tx count", v, 32'(k) << 16);
        tx_push(8'((k ^ 8'h5A) & 255));
      end
      rd(2'd1, v);
      check("R3 tx count held at depth", v, 32'(DEPTH) << 16);
      for (int i = 0; i < DEPTH; i++) begin
        eng_tx_pop = 1'b1;
        step();
        eng_tx_pop = 1'b0;
        check("R4 tx order", {24'd0, eng_tx_data}, 32'((i ^ 8'h5A) & 255));
      end
    end

    // R8 R9 write-one-to-clear and events
    wr(2'd0, 32'h8000_8001);
    rx_push(8'hC3);
    wr(2'd3, 32'hFFFF_FFFF);
    step();
    eng_done = 1'b1; step(); eng_done = 1'b0;
    rd(2'd3, v); check("R9 done sets", v, 32'h1011);
    wr(2'd3, 32'h0000_1000);
    rd(2'd3, v); check("R8 selective clear", v, 32'h0011);
    wr(2'd3, 32'h0000_0001);
    rd(2'd3, v); check("R8 level cleared", v, 32'h0010);
    rd(2'd3, v); check("R8 level re-set", v, 32'h0011);
    eng_done = 1'b1;
    wr(2'd3, 32'h0000_0010);
    eng_done = 1'b0;
    rd(2'd3, v); check("R9 event kept during clear", v, 32'h1001);

    // R10 interrupt line
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h0000_1000);
    check("R10 irq not yet", {31'd0, irq}, 32'd0);
    step();
    check("R10 irq raised", {31'd0, irq}, 32'd1);
    rd(2'd2, v); check("R10 enable readback", v, 32'h1000);
    wr(2'd3, 32'h0000_1000);
    check("R10 irq still high", {31'd0, irq}, 32'd1);
    step();
    check("R10 irq dropped", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h0000_0001);
    step(); step();
    check("R10 irq rx ready", {31'd0, irq}, 32'd1);

    // R11 DMA requests
    check("R11 rx_drq disabled", {31'd0, rx_drq}, 32'd0);
    wr(2'd0, 32'h0000_0101);
    step();
    check("R11 rx_drq enabled", {31'd0, rx_drq}, 32'd1);
    check("R11 tx_drq disabled", {31'd0, tx_drq}, 32'd0);
    wr(2'd0, 32'h0100_0101);
    step();
    check("R11 tx_drq enabled", {31'd0, tx_drq}, 32'd1);
    tx_push(8'h77);
    step();
    check("R11 tx_drq above trigger", {31'd0, tx_drq}, 32'd0);
    wr(2'd0, 32'h0100_0102);
    step();
    check("R11 rx_drq below trigger", {31'd0, rx_drq}, 32'd0);

    // R12 self-clearing flushes
    wr(2'd0, 32'h0100_8102);
    rd(2'd1, v); check("R12 rx flush only", v, 32'h0001_0000);
    rd(2'd0, v); check("R12 flush bit reads 0", v, 32'h0100_0102);
    wr(2'd0, 32'h8100_0102);
    rd(2'd1, v); check("R12 tx flush", v, 32'd0);

    finish_sim();
  end
endmodule